// File: doc/BRIEF.md
# Synchronizable Clock Divider Bank

This block is a set of programmable clock dividers that all run from one input clock and share a single synchronization input. Each channel drives a clock-enable output. The enable pulses high for one input cycle out of every N cycles, where N is that channel's divide ratio. Pulling the shared sync high holds every channel that takes part in synchronization. When sync drops, each of those channels waits its own programmed delay, counted in input cycles, and then restarts. The relative phase of all outputs after a sync is therefore fixed by configuration alone.

Sync can come from the external pin or from software. Software triggers it by flipping a polarity-invert bit that is XORed with the pin. The combined signal is re-clocked through a two-stage synchronizer before it acts. The re-clocked value is also driven out so that downstream devices can be aligned to the same event. Each channel has a participation bit. Once alignment is done, software can clear these bits and reuse the shared path for other periodic traffic without disturbing the running dividers.

Top module: `sync_div_bank`

## Requirements
- R1: While reset is high, every channel enable reads 1, because each channel resets into its running state at count 0. The forwarded sync output reads 0 during reset.
- R2: The effective sync is sync_pin XOR sync_inv. sync_fwd equals the effective sync as sampled two rising clock edges earlier. With pin and invert both high, the effective sync is 0 and nothing is held.
- R3: A channel whose sync_en bit is set has its enable at 0 in every cycle that follows a cycle in which sync_fwd and that sync_en bit were both high.
- R4: Take channel k, with sync_en set and a delay field D. Its first enable pulse after a sync appears exactly D+1 cycles after the first cycle in which sync_fwd is low again. Counted from the clock edge at which the effective sync is first sampled low, this is edge 3+D.
- R5: In the running state, enable pulses repeat every N cycles, where N is the channel's ratio field (1 to 1023). A ratio of 1 gives an enable in every cycle, and a ratio of 0 behaves as 1.
- R6: A channel whose sync_en bit is clear keeps its pulse spacing through any sync assertion.
- R7: A software-only sync, made by raising and then lowering sync_inv with the pin held low, aligns the channels with the same timing as a pin pulse.
- R8: Channel k uses bits [k*10 +: 10] of div_ratio as its ratio and bits [k*8 +: 8] of div_delay as its delay. Bit k of sync_en and bit k of ch_en belong to channel k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that every divider counts |
| rst | input | 1 | Synchronous active-high reset |
| sync_pin | input | 1 | External sync request, asynchronous |
| sync_inv | input | 1 | Software polarity invert applied to sync_pin |
| sync_en | input | NCH | Per-channel participation in sync |
| div_ratio | input | NCH*10 | Packed per-channel divide ratios |
| div_delay | input | NCH*8 | Packed per-channel restart delays |
| ch_en | output | NCH | Per-channel clock-enable pulses |
| sync_fwd | output | 1 | Re-clocked sync forwarded to downstream devices |

## Verification
The forwarded sync follows a change of the effective sync by two rising edges. The hold on a participating channel shows one edge after that. A channel's first enable after release arrives at edge 3+D, counted from the first edge that samples the released sync. All inputs are driven on falling edges, and all outputs are sampled on the falling edge that follows a counted number of rising edges, so each comparison lands in the exact cycle the requirement names. The table-driven part counts edges from the release and predicts every enable from D and N. The directed part finds a reference pulse on an excluded channel and then expects its spacing to continue across a sync pulse.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
    localparam int SDB_NCH         = 4;
    localparam int SDB_DIV_W       = 10;
    localparam int SDB_DLY_W       = 8;
    localparam int SDB_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        CH_RUN  = 2'd0,
        CH_HOLD = 2'd1,
        CH_WAIT = 2'd2
    } ch_mode_e;

    typedef struct packed {
        ch_mode_e              mode;
        logic [SDB_DIV_W-1:0]  cnt;
        logic [SDB_DLY_W-1:0]  dcnt;
    } ch_state_t;

    function automatic logic ratio_wrap(input logic [SDB_DIV_W-1:0] cnt,
                                        input logic [SDB_DIV_W-1:0] ratio);
        return ({1'b0, cnt} + 1'b1) >= {1'b0, ratio};
    endfunction
endpackage

// File: rtl/sdb_resync.sv
module sdb_resync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d_in};
    end

    assign q_out = pipe[STAGES-1];
endmodule

// File: rtl/sdb_channel.sv
module sdb_channel
    import sdb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sync_q,
    input  logic                 part_en,
    input  logic [SDB_DIV_W-1:0] ratio,
    input  logic [SDB_DLY_W-1:0] delay,
    output logic                 pulse
);
    ch_state_t st, nxt;
    logic      hold;

    assign hold = sync_q & part_en;

    always_comb begin
        nxt = st;
        unique case (st.mode)
            CH_RUN: begin
                nxt.cnt = ratio_wrap(st.cnt, ratio) ? '0 : st.cnt + 1'b1;
            end
            CH_HOLD: begin
                if (delay == '0) begin
                    nxt.mode = CH_RUN;
                    nxt.cnt  = '0;
                end else begin
                    nxt.mode = CH_WAIT;
                    nxt.dcnt = delay - 1'b1;
                end
            end
            CH_WAIT: begin
                if (st.dcnt == '0) begin
                    nxt.mode = CH_RUN;
                    nxt.cnt  = '0;
                end else begin
                    nxt.dcnt = st.dcnt - 1'b1;
                end
            end
            default: begin
                nxt.mode = CH_RUN;
                nxt.cnt  = '0;
            end
        endcase
        if (hold) begin
            nxt.mode = CH_HOLD;
            nxt.cnt  = '0;
            nxt.dcnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.mode <= CH_RUN;
            st.cnt  <= '0;
            st.dcnt <= '0;
        end else begin
            st <= nxt;
        end
    end

    assign pulse = (st.mode == CH_RUN) && (st.cnt == '0);
endmodule

// File: rtl/sync_div_bank.sv
module sync_div_bank
    import sdb_pkg::*;
#(
    parameter int NCH = SDB_NCH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sync_pin,
    input  logic                     sync_inv,
    input  logic [NCH-1:0]           sync_en,
    input  logic [NCH*SDB_DIV_W-1:0] div_ratio,
    input  logic [NCH*SDB_DLY_W-1:0] div_delay,
    output logic [NCH-1:0]           ch_en,
    output logic                     sync_fwd
);
    logic sync_raw;
    logic sync_q;

    assign sync_raw = sync_pin ^ sync_inv;

    sdb_resync #(.STAGES(SDB_SYNC_STAGES)) u_resync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (sync_raw),
        .q_out (sync_q)
    );

    assign sync_fwd = sync_q;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        sdb_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .sync_q  (sync_q),
            .part_en (sync_en[k]),
            .ratio   (div_ratio[k*SDB_DIV_W +: SDB_DIV_W]),
            .delay   (div_delay[k*SDB_DLY_W +: SDB_DLY_W]),
            .pulse   (ch_en[k])
        );
    end
endmodule

// File: rtl/sdb_checker.sv
module sdb_checker
    import sdb_pkg::*;
#(
    parameter int NCH = SDB_NCH
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     sync_pin,
    input logic                     sync_inv,
    input logic [NCH-1:0]           sync_en,
    input logic [NCH*SDB_DIV_W-1:0] div_ratio,
    input logic [NCH*SDB_DLY_W-1:0] div_delay,
    input logic [NCH-1:0]           ch_en,
    input logic                     sync_fwd
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)           cyc <= '0;
        else if (cyc != 3) cyc <= cyc + 1'b1;
    end

    AST_FWD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2) |-> (sync_fwd == $past(sync_pin ^ sync_inv, 2))); // R2

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
            (cyc >= 1 && $past(sync_fwd && sync_en[k])) |-> !ch_en[k]); // R3

        AST_PULSE_GAP: assert property (@(posedge clk) disable iff (rst)
            (cyc >= 1 && $past(ch_en[k]) && $past(div_ratio[k*SDB_DIV_W +: SDB_DIV_W]) > 1)
            |-> !ch_en[k]); // R5

        AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
            (cyc >= 1 && $past(ch_en[k]) && $past(!sync_en[k])
             && $past(div_ratio[k*SDB_DIV_W +: SDB_DIV_W]) <= 1)
            |-> ch_en[k]); // R6
    end
endmodule

bind sync_div_bank sdb_checker #(.NCH(NCH)) u_sdb_checker (.*);

// File: tb/sync_div_bank_test.sv
module sync_div_bank_test;
    localparam int NCH = 4;
    localparam int DW  = 10;
    localparam int LW  = 8;
    localparam int NV  = 4;
    localparam int SPAN = 40;

    // vector table: ratio, delay per channel, participation mask, software trigger
    localparam int V_RAT [NV][NCH] = '{'{4, 4, 4, 4}, '{1, 2, 3, 5},
                                       '{0, 6, 1, 2}, '{3, 8, 10, 1}};
    localparam int V_DLY [NV][NCH] = '{'{0, 1, 2, 3}, '{0, 0, 7, 2},
                                       '{5, 3, 0, 0}, '{1, 12, 0, 4}};
    localparam int V_SEN [NV]      = '{4'b1111, 4'b1111, 4'b1011, 4'b0111};
    localparam int V_INV [NV]      = '{0, 1, 0, 1};

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                sync_pin = 1'b0;
    logic                sync_inv = 1'b0;
    logic [NCH-1:0]      sync_en = '1;
    logic [NCH*DW-1:0]   div_ratio = '0;
    logic [NCH*LW-1:0]   div_delay = '0;
    logic [NCH-1:0]      ch_en;
    logic                sync_fwd;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    sync_div_bank #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .sync_pin(sync_pin), .sync_inv(sync_inv),
        .sync_en(sync_en), .div_ratio(div_ratio), .div_delay(div_delay),
        .ch_en(ch_en), .sync_fwd(sync_fwd)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_vec(input int v);
        for (int k = 0; k < NCH; k++) begin
            div_ratio[k*DW +: DW] = DW'(V_RAT[v][k]);
            div_delay[k*LW +: LW] = LW'(V_DLY[v][k]);
        end
        sync_en = NCH'(V_SEN[v]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int first;
        int rr;
        int exp_en;
        // R1: reset state
        sync_pin = 1'b1;
        edges(3);
        check("R1 ch_en in reset", int'(ch_en), 4'hF);
        check("R1 sync_fwd in reset", int'(sync_fwd), 0);
        sync_pin = 1'b0;
        for (int k = 0; k < NCH; k++) div_ratio[k*DW +: DW] = 10'd1;
        edges(1);
        rst = 1'b0;
        edges(4);

        // R2: pin and invert cancel; exact latency of forwarded sync
        sync_pin = 1'b1;
        sync_inv = 1'b1;
        edges(6);
        check("R2 cancelled sync_fwd", int'(sync_fwd), 0);
        check("R2 cancelled no hold", int'(ch_en), 4'hF);
        sync_inv = 1'b0;
        edges(1);
        check("R2 fwd after 1 edge", int'(sync_fwd), 0);
        edges(1);
        check("R2 fwd after 2 edges", int'(sync_fwd), 1);
        sync_pin = 1'b0;
        edges(1);
        check("R2 fwd fall after 1 edge", int'(sync_fwd), 1);
        edges(1);
        check("R2 fwd fall after 2 edges", int'(sync_fwd), 0);
        edges(8);

        // table walk: R3 hold, R4 restart phase, R5 period, R6/R7/R8
        for (int v = 0; v < NV; v++) begin
            load_vec(v);
            sync_pin = 1'b0;
            sync_inv = 1'b0;
            edges(4);
            if (V_INV[v] != 0) sync_inv = 1'b1;
            else               sync_pin = 1'b1;
            edges(5);
            check("R3 sync_fwd high in hold", int'(sync_fwd), 1);
            for (int k = 0; k < NCH; k++)
                check($sformatf("R3 R6 v%0d ch%0d during hold", v, k),
                      int'(ch_en[k]), V_SEN[v][k] ? 0 : 1);
            sync_pin = 1'b0;
            sync_inv = 1'b0;
            for (int e = 1; e <= SPAN; e++) begin
                edges(1);
                for (int k = 0; k < NCH; k++) begin
                    rr = (V_RAT[v][k] == 0) ? 1 : V_RAT[v][k];
                    first = 3 + V_DLY[v][k];
                    if (!V_SEN[v][k])      exp_en = 1;
                    else if (e < first)    exp_en = 0;
                    else                   exp_en = (((e - first) % rr) == 0) ? 1 : 0;
                    check($sformatf("R4 R5 R7 R8 v%0d ch%0d edge%0d", v, k, e),
                          int'(ch_en[k]), exp_en);
                end
            end
        end

        // R6: excluded channel with ratio 4 keeps spacing through a pin sync
        div_ratio[0 +: DW] = 10'd4;
        sync_en = 4'b1110;
        edges(6);
        begin
            int found = 0;
            for (int i = 0; i < 8 && found == 0; i++) begin
                if (ch_en[0]) found = 1;
                else edges(1);
            end
            check("R6 reference pulse found", found, 1);
        end
        for (int j = 1; j <= 30; j++) begin
            if (j == 5)  sync_pin = 1'b1;
            if (j == 13) sync_pin = 1'b0;
            edges(1);
            check($sformatf("R6 excluded ch0 step%0d", j), int'(ch_en[0]),
                  ((j % 4) == 0) ? 1 : 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule